// File: doc/BRIEF.md
# System Exception Control Register Front End

This block is the software-visible register layer that sits beside an interrupt controller's arbitration core. It reads the core's per-exception pending, active and enable state and the two vector numbers the core reports, the one being serviced and the best one waiting. It presents these through a few 32-bit registers on a simple synchronous port. Writes to those registers produce one-cycle set-pending and clear-pending strobes for the non-maskable, pendable-service and tick exceptions, a software trigger for external interrupts, and a keyed system reset request. It also holds the vector table base and three fault enable bits.

External interrupts are numbered from vector 16 upward. Vectors below 16 are system exceptions. The access port is controlled by a three-state machine. ST_IDLE means the previous cycle had no access. ST_RD_RESP means the previous cycle accepted a read, and the read data is presented now. ST_WR_RESP means the previous cycle accepted a write, and its strobes are driven now. Every cycle the machine moves to ST_WR_RESP when wr_en is high, else to ST_RD_RESP when rd_en is high, else to ST_IDLE. A write in the same cycle as a read takes precedence and the read is dropped.

Top module: `irq_sysctl_regs`

## Requirements
- R1: After reset all strobes, reset_req, rd_valid, fault_en and vtor are zero.
- R2: A write to offset 0xD04 with bit 31 set pulses nmi_set for one cycle, in the cycle after the write.
- R3: At 0xD04, bit 28 pulses psv_set. Bit 27 pulses psv_clr only when bit 28 is clear, so setting wins over clearing.
- R4: At 0xD04, bit 26 pulses tick_set. Bit 25 pulses tick_clr only when bit 26 is clear.
- R5: A read of 0xD04 returns the active vector in bits 8:0, or 0 when active_valid is low. It returns the pending vector in bits 20:12, or 0 when pend_valid is low.
- R6: A read of 0xD04 sets bit 22 when any external interrupt is pending. It sets bit 11 when an external interrupt other than the active vector is active. Bits 26, 28 and 31 mirror tick, pendable-service and non-maskable pending.
- R7: A write to 0xD08 stores the data with bits 6:0 forced to zero. The stored value appears on vtor and reads back from 0xD08.
- R8: A write to 0xD0C with bits 31:16 equal to 0x05FA and bit 2 set pulses reset_req for one cycle. Any other key leaves reset_req low. A read of 0xD0C returns 0xFA050000.
- R9: A read of 0xD24 shows active state in bits 0, 1, 3, 7, 8, 10 and 11 (memory, bus, usage, supervisor call, debug, pendable service, tick). It shows pending state in bits 12, 13, 14 and 15 (usage, memory, bus, supervisor call).
- R10: Bits 16, 17 and 18 written to 0xD24 set fault_en[0] (memory), fault_en[1] (bus) and fault_en[2] (usage), and read back in place. The other bits written there have no effect.
- R11: A write to 0xF00 takes bits 8:0 as an external interrupt index. When the index is below NUM_IRQ it pulses ext_trig, with ext_trig_num holding the index. Otherwise nothing happens.
- R12: A read of 0x004 returns NUM_IRQ/32 - 1.
- R13: Unmapped offsets read as zero, and writes to them change no register and raise no strobe.
- R14: Read data and rd_valid appear in the cycle after rd_en is sampled. rd_valid is high for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request this cycle |
| wr_en | input | 1 | Write request this cycle |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_valid |
| rd_valid | output | 1 | Read response cycle |
| sys_pend | input | 7 | Pending: [0] non-maskable, [1] pendable service, [2] tick, [3] memory, [4] bus, [5] usage, [6] supervisor call |
| sys_act | input | 7 | Active: [0] memory, [1] bus, [2] usage, [3] supervisor call, [4] debug, [5] pendable service, [6] tick |
| ext_pending | input | NUM_IRQ | Pending flags of external interrupts |
| ext_active | input | NUM_IRQ | Active flags of external interrupts (bit i is vector 16+i) |
| active_valid | input | 1 | A vector is being serviced |
| active_vec | input | 9 | Vector number being serviced |
| pend_valid | input | 1 | A vector is waiting |
| pend_vec | input | 9 | Highest waiting vector number |
| nmi_set | output | 1 | Set non-maskable pending strobe |
| psv_set | output | 1 | Set pendable-service pending strobe |
| psv_clr | output | 1 | Clear pendable-service pending strobe |
| tick_set | output | 1 | Set tick pending strobe |
| tick_clr | output | 1 | Clear tick pending strobe |
| ext_trig | output | 1 | Software trigger strobe for an external interrupt |
| ext_trig_num | output | 9 | External interrupt index for ext_trig |
| fault_en | output | 3 | Enables: [0] memory, [1] bus, [2] usage fault |
| vtor | output | 32 | Vector table base |
| reset_req | output | 1 | System reset request pulse |

## Verification
Every result of this block is due exactly one cycle after the access that causes it. Strobes and reset_req rise in the cycle after the write edge and fall one cycle later. rdata and rd_valid are registered at the edge that samples rd_en. Stored state (vtor, fault_en) is updated by the write edge. The bench drives each access at a falling edge and removes it at the next falling edge, where it samples. That sample falls midway through the response cycle. One falling edge later it checks that each pulse has dropped.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned VEC_W  = 9;
    localparam int unsigned EXT_BASE = 16;

    // register byte offsets, fixed by software
    localparam logic [ADDR_W-1:0] OFS_TYPE  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'hD04;
    localparam logic [ADDR_W-1:0] OFS_VTOR  = 12'hD08;
    localparam logic [ADDR_W-1:0] OFS_RSTC  = 12'hD0C;
    localparam logic [ADDR_W-1:0] OFS_HSTAT = 12'hD24;
    localparam logic [ADDR_W-1:0] OFS_TRIG  = 12'hF00;

    localparam logic [15:0]       RSTC_KEY  = 16'h05FA;
    localparam logic [DATA_W-1:0] RSTC_READ = 32'hFA05_0000;
    localparam int unsigned       VTOR_LSB  = 7;

    // index into sys_pend
    localparam int unsigned P_NMI = 0, P_PSV = 1, P_TICK = 2, P_MEM = 3,
                            P_BUS = 4, P_USE = 5, P_SVC = 6;
    localparam int unsigned NUM_PEND = 7;
    // index into sys_act
    localparam int unsigned A_MEM = 0, A_BUS = 1, A_USE = 2, A_SVC = 3,
                            A_DBG = 4, A_PSV = 5, A_TICK = 6;
    localparam int unsigned NUM_ACT = 7;
    localparam int unsigned NUM_FEN = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_RESP = 2'd1,
        ST_WR_RESP = 2'd2
    } port_state_e;

    typedef struct packed {
        logic             nmi_set;
        logic             psv_set;
        logic             psv_clr;
        logic             tick_set;
        logic             tick_clr;
        logic             trig;
        logic [VEC_W-1:0] trig_num;
        logic             rst_req;
        logic             vtor_we;
        logic             fen_we;
    } wr_cmd_t;

endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
    import irq_regs_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64
) (
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [15:0]             wdata_hi,
    input  logic [VEC_W-1:0]        wdata_lo,
    output wr_cmd_t                 cmd
);
    // bit positions inside wdata_hi (word bit minus 16)
    localparam int unsigned H_NMI_SET  = 31 - 16;
    localparam int unsigned H_PSV_SET  = 28 - 16;
    localparam int unsigned H_PSV_CLR  = 27 - 16;
    localparam int unsigned H_TICK_SET = 26 - 16;
    localparam int unsigned H_TICK_CLR = 25 - 16;
    localparam int unsigned L_RST_REQ  = 2;
    localparam logic [VEC_W:0] IRQ_LIMIT = (VEC_W+1)'(NUM_IRQ);

    logic hit_ctrl, hit_rstc, hit_trig;

    always_comb begin
        hit_ctrl = wr_en && (addr == OFS_CTRL);
        hit_rstc = wr_en && (addr == OFS_RSTC);
        hit_trig = wr_en && (addr == OFS_TRIG);

        cmd          = '0;
        cmd.nmi_set  = hit_ctrl && wdata_hi[H_NMI_SET];
        cmd.psv_set  = hit_ctrl && wdata_hi[H_PSV_SET];
        cmd.psv_clr  = hit_ctrl && !wdata_hi[H_PSV_SET] && wdata_hi[H_PSV_CLR];
        cmd.tick_set = hit_ctrl && wdata_hi[H_TICK_SET];
        cmd.tick_clr = hit_ctrl && !wdata_hi[H_TICK_SET] && wdata_hi[H_TICK_CLR];
        cmd.trig     = hit_trig && ({1'b0, wdata_lo} < IRQ_LIMIT);
        cmd.trig_num = wdata_lo;
        cmd.rst_req  = hit_rstc && (wdata_hi == RSTC_KEY) && wdata_lo[L_RST_REQ];
        cmd.vtor_we  = wr_en && (addr == OFS_VTOR);
        cmd.fen_we   = wr_en && (addr == OFS_HSTAT);
    end

endmodule

// File: rtl/irq_state_summary.sv
module irq_state_summary
    import irq_regs_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64
) (
    input  logic [NUM_IRQ-1:0] ext_pending,
    input  logic [NUM_IRQ-1:0] ext_active,
    input  logic               active_valid,
    input  logic [VEC_W-1:0]   active_vec,
    output logic               any_ext_pend,
    output logic               other_ext_active
);
    logic [NUM_IRQ-1:0] act_other;

    // mask out the vector currently being serviced
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_mask
        localparam logic [VEC_W-1:0] MY_VEC = VEC_W'(EXT_BASE + i);
        assign act_other[i] = ext_active[i] &&
                              !(active_valid && (active_vec == MY_VEC));
    end

    assign any_ext_pend     = |ext_pending;
    assign other_ext_active = |act_other;

endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
    import irq_regs_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PEND-1:0] sys_pend,
    input  logic [NUM_ACT-1:0]  sys_act,
    input  logic                active_valid,
    input  logic [VEC_W-1:0]    active_vec,
    input  logic                pend_valid,
    input  logic [VEC_W-1:0]    pend_vec,
    input  logic                any_ext_pend,
    input  logic                other_ext_active,
    input  logic [NUM_FEN-1:0]  fen_q,
    input  logic [DATA_W-1:0]   vtor_q,
    output logic [DATA_W-1:0]   rd_word
);
    localparam logic [DATA_W-1:0] TYPE_VAL = DATA_W'(NUM_IRQ / 32 - 1);

    logic [DATA_W-1:0] ctrl_word, hstat_word;

    always_comb begin
        ctrl_word = '0;
        if (active_valid) ctrl_word[8:0]   = active_vec;
        if (pend_valid)   ctrl_word[20:12] = pend_vec;
        ctrl_word[11] = other_ext_active;
        ctrl_word[22] = any_ext_pend;
        ctrl_word[26] = sys_pend[P_TICK];
        ctrl_word[28] = sys_pend[P_PSV];
        ctrl_word[31] = sys_pend[P_NMI];

        hstat_word        = '0;
        hstat_word[0]     = sys_act[A_MEM];
        hstat_word[1]     = sys_act[A_BUS];
        hstat_word[3]     = sys_act[A_USE];
        hstat_word[7]     = sys_act[A_SVC];
        hstat_word[8]     = sys_act[A_DBG];
        hstat_word[10]    = sys_act[A_PSV];
        hstat_word[11]    = sys_act[A_TICK];
        hstat_word[12]    = sys_pend[P_USE];
        hstat_word[13]    = sys_pend[P_MEM];
        hstat_word[14]    = sys_pend[P_BUS];
        hstat_word[15]    = sys_pend[P_SVC];
        hstat_word[18:16] = fen_q;

        unique case (addr)
            OFS_TYPE:  rd_word = TYPE_VAL;
            OFS_CTRL:  rd_word = ctrl_word;
            OFS_VTOR:  rd_word = vtor_q;
            OFS_RSTC:  rd_word = RSTC_READ;
            OFS_HSTAT: rd_word = hstat_word;
            default:   rd_word = '0;
        endcase
    end

endmodule

// File: rtl/irq_sysctl_regs.sv
module irq_sysctl_regs
    import irq_regs_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [11:0]          addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    output logic                 rd_valid,
    input  logic [6:0]           sys_pend,
    input  logic [6:0]           sys_act,
    input  logic [NUM_IRQ-1:0]   ext_pending,
    input  logic [NUM_IRQ-1:0]   ext_active,
    input  logic                 active_valid,
    input  logic [8:0]           active_vec,
    input  logic                 pend_valid,
    input  logic [8:0]           pend_vec,
    output logic                 nmi_set,
    output logic                 psv_set,
    output logic                 psv_clr,
    output logic                 tick_set,
    output logic                 tick_clr,
    output logic                 ext_trig,
    output logic [8:0]           ext_trig_num,
    output logic [2:0]           fault_en,
    output logic [31:0]          vtor,
    output logic                 reset_req
);
    port_state_e       state_q, state_d;
    wr_cmd_t           cmd_d, cmd_q;
    logic [DATA_W-1:0] rd_word, rdata_q, vtor_q;
    logic [NUM_FEN-1:0] fen_q;
    logic              any_ext_pend, other_ext_active;

    irq_wr_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata_hi (wdata[31:16]),
        .wdata_lo (wdata[8:0]),
        .cmd      (cmd_d)
    );

    irq_state_summary #(.NUM_IRQ(NUM_IRQ)) u_sum (
        .ext_pending      (ext_pending),
        .ext_active       (ext_active),
        .active_valid     (active_valid),
        .active_vec       (active_vec),
        .any_ext_pend     (any_ext_pend),
        .other_ext_active (other_ext_active)
    );

    irq_rd_mux #(.NUM_IRQ(NUM_IRQ)) u_rd (
        .addr             (addr),
        .sys_pend         (sys_pend),
        .sys_act          (sys_act),
        .active_valid     (active_valid),
        .active_vec       (active_vec),
        .pend_valid       (pend_valid),
        .pend_vec         (pend_vec),
        .any_ext_pend     (any_ext_pend),
        .other_ext_active (other_ext_active),
        .fen_q            (fen_q),
        .vtor_q           (vtor_q),
        .rd_word          (rd_word)
    );

    // next state: a write outranks a read in the same cycle
    always_comb begin
        if (wr_en)      state_d = ST_WR_RESP;
        else if (rd_en) state_d = ST_RD_RESP;
        else            state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // data captured alongside the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            rdata_q <= '0;
            vtor_q  <= '0;
            fen_q   <= '0;
        end else begin
            cmd_q <= cmd_d;
            if (state_d == ST_RD_RESP) rdata_q <= rd_word;
            if (cmd_d.vtor_we)
                vtor_q <= {wdata[DATA_W-1:VTOR_LSB], VTOR_LSB'(0)};
            if (cmd_d.fen_we) fen_q <= wdata[18:16];
        end
    end

    // outputs by state
    always_comb begin
        rd_valid     = 1'b0;
        rdata        = rdata_q;
        nmi_set      = 1'b0;
        psv_set      = 1'b0;
        psv_clr      = 1'b0;
        tick_set     = 1'b0;
        tick_clr     = 1'b0;
        ext_trig     = 1'b0;
        ext_trig_num = cmd_q.trig_num;
        reset_req    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RD_RESP: rd_valid = 1'b1;
            ST_WR_RESP: begin
                nmi_set   = cmd_q.nmi_set;
                psv_set   = cmd_q.psv_set;
                psv_clr   = cmd_q.psv_clr;
                tick_set  = cmd_q.tick_set;
                tick_clr  = cmd_q.tick_clr;
                ext_trig  = cmd_q.trig;
                reset_req = cmd_q.rst_req;
            end
            default: ;
        endcase
    end

    assign fault_en = fen_q;
    assign vtor     = vtor_q;

endmodule

// File: rtl/irq_sysctl_regs_chk.sv
module irq_sysctl_regs_chk
    import irq_regs_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic        wr_en,
    input logic [11:0] addr,
    input logic [31:0] wdata,
    input logic        rd_valid,
    input logic        nmi_set,
    input logic        psv_set,
    input logic        psv_clr,
    input logic        tick_set,
    input logic        tick_clr,
    input logic        ext_trig,
    input logic [8:0]  ext_trig_num,
    input logic [2:0]  fault_en,
    input logic        reset_req
);
    assert_nmi_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CTRL && wdata[31]) |=> nmi_set);

    assert_psv_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(psv_set && psv_clr));

    assert_tick_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_set && tick_clr));

    assert_reset_keyed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(wr_en && addr == OFS_RSTC &&
                            wdata[31:16] == RSTC_KEY && wdata[2]));

    assert_fault_en_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFS_HSTAT) |=> $stable(fault_en));

    assert_trig_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ext_trig |-> ({23'd0, ext_trig_num} < 32'(NUM_IRQ)));

    assert_read_response_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> rd_valid);

endmodule

bind irq_sysctl_regs irq_sysctl_regs_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .rd_valid     (rd_valid),
    .nmi_set      (nmi_set),
    .psv_set      (psv_set),
    .psv_clr      (psv_clr),
    .tick_set     (tick_set),
    .tick_clr     (tick_clr),
    .ext_trig     (ext_trig),
    .ext_trig_num (ext_trig_num),
    .fault_en     (fault_en),
    .reset_req    (reset_req)
);

// File: tb/irq_sysctl_regs_tb.sv
module irq_sysctl_regs_tb;
    localparam int NUM_IRQ = 64;
    localparam int ROWS = 12;
    // row: {is_read, addr[11:0], wdata[31:0], expected[31:0]}
    localparam logic [76:0] TABLE [0:ROWS-1] = '{
        {1'b0, 12'hD08, 32'h2000_00FF, 32'h0},
        {1'b1, 12'hD08, 32'h0,         32'h2000_0080},
        {1'b1, 12'h004, 32'h0,         32'h0000_0001},
        {1'b1, 12'hD0C, 32'h0,         32'hFA05_0000},
        {1'b1, 12'hD04, 32'h0,         32'h0400_5814},
        {1'b0, 12'hD24, 32'h0007_0000, 32'h0},
        {1'b1, 12'hD24, 32'h0,         32'h0007_2801},
        {1'b0, 12'hD24, 32'h0002_FFFF, 32'h0},
        {1'b1, 12'hD24, 32'h0,         32'h0002_2801},
        {1'b0, 12'h100, 32'hFFFF_FFFF, 32'h0},
        {1'b1, 12'h100, 32'h0,         32'h0},
        {1'b1, 12'hD08, 32'h0,         32'h2000_0080}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_en = 1'b0, wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic rd_valid;
    logic [6:0] sys_pend = '0, sys_act = '0;
    logic [NUM_IRQ-1:0] ext_pending = '0, ext_active = '0;
    logic active_valid = 1'b0, pend_valid = 1'b0;
    logic [8:0] active_vec = '0, pend_vec = '0;
    logic nmi_set, psv_set, psv_clr, tick_set, tick_clr, ext_trig, reset_req;
    logic [8:0] ext_trig_num;
    logic [2:0] fault_en;
    logic [31:0] vtor;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_sysctl_regs #(.NUM_IRQ(NUM_IRQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
        .sys_pend(sys_pend), .sys_act(sys_act),
        .ext_pending(ext_pending), .ext_active(ext_active),
        .active_valid(active_valid), .active_vec(active_vec),
        .pend_valid(pend_valid), .pend_vec(pend_vec),
        .nmi_set(nmi_set), .psv_set(psv_set), .psv_clr(psv_clr),
        .tick_set(tick_set), .tick_clr(tick_clr),
        .ext_trig(ext_trig), .ext_trig_num(ext_trig_num),
        .fault_en(fault_en), .vtor(vtor), .reset_req(reset_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] strobes();
        return {22'd0, ext_trig_num & {9{ext_trig}}, reset_req, ext_trig,
                tick_clr, tick_set, psv_clr, psv_set, nmi_set};
    endfunction

    function automatic string row_req(input int i);
        case (i)
            2: return "R12";
            3: return "R8";
            4: return "R5";
            6, 8: return "R10";
            10: return "R13";
            default: return "R7";
        endcase
    endfunction

    // write: outputs due in the cycle after the write edge
    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic do_read(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0; addr = '0;
        check("R14", {31'd0, rd_valid}, 32'd1);
        check(req, rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R14 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while and after reset
        check("R1", strobes(), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {28'd0, rd_valid, fault_en}, 32'd0);
        check("R1", vtor, 32'd0);

        // table-driven register walk with fixed status inputs
        sys_pend = 7'b000_1100;                  // tick, memory
        sys_act  = 7'b100_0001;                  // tick, memory
        ext_active = '0;
        ext_active[4] = 1'b1;
        ext_active[9] = 1'b1;
        active_valid = 1'b1; active_vec = 9'd20;
        pend_valid = 1'b1; pend_vec = 9'd5;
        for (int i = 0; i < ROWS; i++) begin
            if (TABLE[i][76]) begin
                do_read(row_req(i), TABLE[i][75:64], TABLE[i][31:0]);
            end else begin
                do_write(TABLE[i][75:64], TABLE[i][63:32]);
                check("R13", strobes(), 32'd0);
                check("R14", {31'd0, rd_valid}, 32'd0);
            end
        end
        check("R7", vtor, 32'h2000_0080);
        check("R10", {29'd0, fault_en}, 32'd2);

        // R2: non-maskable set strobe, then it drops
        do_write(12'hD04, 32'h8000_0000);
        check("R2", strobes(), 32'h1);
        @(negedge clk);
        check("R2", strobes(), 32'h0);

        // R3: set outranks clear, clear alone
        do_write(12'hD04, 32'h1800_0000);
        check("R3", strobes(), 32'h2);
        do_write(12'hD04, 32'h0800_0000);
        check("R3", strobes(), 32'h4);

        // R4: same pairing for tick
        do_write(12'hD04, 32'h0600_0000);
        check("R4", strobes(), 32'h8);
        do_write(12'hD04, 32'h0200_0000);
        check("R4", strobes(), 32'h10);

        // R8: keyed reset request
        do_write(12'hD0C, 32'h05FA_0004);
        check("R8", strobes(), 32'h40);
        @(negedge clk);
        check("R8", strobes(), 32'h0);
        do_write(12'hD0C, 32'h05FB_0004);
        check("R8", strobes(), 32'h0);
        do_write(12'hD0C, 32'h05FA_0003);
        check("R8", strobes(), 32'h0);

        // R11: software trigger range and masking to 9 bits
        do_write(12'hF00, 32'h0000_0E05);
        check("R11", strobes(), (32'd5 << 7) | 32'h20);
        do_write(12'hF00, 32'd64);
        check("R11", strobes(), 32'h0);
        do_write(12'hF00, 32'h0000_023F);
        check("R11", strobes(), (32'd63 << 7) | 32'h20);

        // R6: summary bits
        sys_pend = 7'b000_0011;                  // non-maskable, pendable service
        ext_pending = '0; ext_pending[40] = 1'b1;
        ext_active = '0;  ext_active[4] = 1'b1;  // only the current one
        active_valid = 1'b1; active_vec = 9'd20;
        pend_valid = 1'b0;
        do_read("R6", 12'hD04, 32'h9040_0014);
        active_vec = 9'd3;
        ext_active = '0; ext_active[0] = 1'b1;
        ext_pending = '0; sys_pend = '0;
        do_read("R6", 12'hD04, 32'h0000_0803);

        // R5: nothing active or pending reads as zero fields
        active_valid = 1'b0; ext_active = '0;
        do_read("R5", 12'hD04, 32'h0);
        pend_valid = 1'b1; pend_vec = 9'd79;
        do_read("R5", 12'hD04, 32'h0004_F000);

        // R9: every handler status bit
        sys_act = 7'h7F; sys_pend = 7'b111_1000;
        do_read("R9", 12'hD24, 32'h0002_FD8B);

        // R14: read dropped when a write arrives in the same cycle
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; addr = 12'h100; wdata = 32'h0;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R14", {31'd0, rd_valid}, 32'd0);
        @(negedge clk);
        check("R14", {31'd0, rd_valid}, 32'd0);

        finish_run();
    end

endmodule